// File: doc/BRIEF.md
# Dual-Speed Bus Cycle Timer

This block stands between a processor bus and the memory system and decides how many master-clock ticks each bus access occupies. Every access runs either as a fast cycle, lined up on a 5-tick grid and sometimes stretched by a DRAM refresh slot, or as a slow cycle, lined up on the 14-tick beats of a 912-tick line whose last beats are 16 ticks long. The choice depends on the region flags supplied with the access, a software-visible speed register, and four disk-motor detectors that watch the bus for motor on/off addresses.

Two free-running phase counters record where the bus stands. One runs in the 50-tick refresh window and the other in the 912-tick line. Both move forward by the length of each access. The block holds its ready output low for the length of the access minus one tick and then raises it for a single tick. The CPU side waits for that tick.

Top module: `bus_speed_timer`

## Requirements
- R1: After reset the speed register reads 0x40, ready is low, the reported length is 0, both phase counters are 0 and all motor detectors are off.
- R2: When the speed-write enable is high at a clock edge, the speed readback shows the written byte from the next cycle on. All eight bits read back exactly as written.
- R3: An access is slow when the region-slow flag is high, or when speed register bit 7 is 0. When neither holds, and neither R4 nor R5 applies, the access is fast.
- R4: Each accepted access to address 0xC0n9, with n = C, D, E, F, turns on motor detector 0, 1, 2, 3. An access to 0xC0n8 turns it off. An access is slow if any detector is on while its enable bit (speed register bit 0..3, same index) is set. The decision uses the detector state from before the access.
- R5: A write to a region flagged as shadowed is always slow. A read from that region follows R3 and R4.
- R6: A slow access at line phase p takes W + L ticks. Let m = p mod 14. The short beat length is 16 when p ≥ 896 and 14 otherwise. W is 0 when m = 0 and otherwise the short beat length minus m. L is 16 when (p + W) mod 912 ≥ 896 and 14 otherwise.
- R7: A fast access at refresh phase f takes (5 − f mod 5) mod 5 ticks plus 5 ticks.
- R8: A fast access adds 5 ticks when f ≥ 45 and the target is writable RAM (the RAM flag is high), whether the access reads or writes.
- R9: After each access the refresh phase becomes (f + D) mod 50 and the line phase becomes (p + D) mod 912, where D is that access's length. Idle cycles leave both phases unchanged.
- R10: An access accepted at a clock edge holds ready low for D − 1 cycles and then raises ready for exactly one cycle. The length output shows D from the cycle after acceptance.
- R11: While a cycle is in progress, the access strobe is ignored. The phases and the motor detectors stay as they were. A strobe during the ready cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 16 | Low 16 bits of the access address |
| acc_write | input | 1 | 1 = write access |
| rgn_slow | input | 1 | Target region always runs slow |
| rgn_shadow | input | 1 | Target region is shadowed |
| rgn_ram | input | 1 | Target is writable RAM (subject to refresh) |
| spd_wr_en | input | 1 | Speed register write enable |
| spd_wr_data | input | 8 | Speed register write data |
| acc_ready | output | 1 | One-tick pulse that ends the access |
| acc_len | output | 6 | Length in ticks of the most recent access |
| spd_q | output | 8 | Speed register readback |

## Verification
On every cycle, the embedded assertions check several properties. The speed register captures a write. Both phase counters stay inside their windows. Ready never lasts two cycles. The countdown of a cycle in progress drops by exactly one per tick. A matched motor address sets its detector. Fast and slow lengths stay within their bounds.

Other properties only the bench's scenarios can show. These are the exact lengths from the alignment and refresh formulas, and that phases carry correctly from one access to the next. They also include that strobes arriving mid-cycle leave no trace, and that the motor detectors feed the speed decision with their state from before the access. The bench shows these by checking each measured ready delay against a model that tracks the phases, the detectors and the speed register.

// File: rtl/bst_pkg.sv
package bst_pkg;
  localparam int DUR_W = 6;
  typedef logic [DUR_W-1:0] dur_t;
endpackage

// File: rtl/bst_speed_sel.sv
module bst_speed_sel #(
  parameter int          SLOTS     = 4,
  parameter int          FAST_BIT  = 7,
  parameter logic [7:0]  IO_PAGE   = 8'hC0,
  parameter logic [3:0]  FIRST_NIB = 4'hC
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  logic [15:0] addr,
  input  logic        write,
  input  logic        rgn_slow,
  input  logic        rgn_shadow,
  input  logic [7:0]  spd,
  output logic        slow
);
  logic [SLOTS-1:0] motor;

  for (genvar i = 0; i < SLOTS; i++) begin : g_motor
    localparam logic [3:0] NIB = FIRST_NIB + 4'(i);
    logic hit;
    logic flag_q;
    assign hit = (addr[15:8] == IO_PAGE) && (addr[7:4] == NIB) && (addr[3:1] == 3'b100);
    always_ff @(posedge clk) begin
      if (rst)               flag_q <= 1'b0;
      else if (accept && hit) flag_q <= addr[0];
    end
    assign motor[i] = flag_q;

    // R4
    motor_set_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && addr == {IO_PAGE, NIB, 4'h9}) |=> motor[i]);
  end

  always_comb begin
    slow = rgn_slow
         | ~spd[FAST_BIT]
         | (|(spd[SLOTS-1:0] & motor))
         | (rgn_shadow & write);
  end
endmodule

// File: rtl/bst_slow_calc.sv
module bst_slow_calc
  import bst_pkg::*;
#(
  parameter int LINE_TICKS = 912,
  parameter int BEAT_SHORT = 14,
  parameter int BEAT_LONG  = 16,
  parameter int LONG_START = 896,
  localparam int PW = $clog2(LINE_TICKS)
) (
  input  logic [PW-1:0] phase,
  output dur_t          dur
);
  int ph, rem, cur_len, align, start, beat;

  always_comb begin
    ph      = int'(phase);
    rem     = ph % BEAT_SHORT;
    cur_len = (ph >= LONG_START) ? BEAT_LONG : BEAT_SHORT;
    align   = (rem == 0) ? 0 : cur_len - rem;
    start   = ph + align;
    if (start >= LINE_TICKS) start = start - LINE_TICKS;
    beat    = (start >= LONG_START) ? BEAT_LONG : BEAT_SHORT;
    dur     = DUR_W'(align + beat);
  end
endmodule

// File: rtl/bst_fast_calc.sv
module bst_fast_calc
  import bst_pkg::*;
#(
  parameter int WIN_TICKS     = 50,
  parameter int FAST_TICKS    = 5,
  parameter int REFRESH_START = 45,
  parameter int REFRESH_TICKS = 5,
  localparam int PW = $clog2(WIN_TICKS)
) (
  input  logic [PW-1:0] phase,
  input  logic          ram,
  output dur_t          dur
);
  int ph, rem, align, refr;

  always_comb begin
    ph    = int'(phase);
    rem   = ph % FAST_TICKS;
    align = (rem == 0) ? 0 : FAST_TICKS - rem;
    refr  = (ph >= REFRESH_START && ram) ? REFRESH_TICKS : 0;
    dur   = DUR_W'(align + FAST_TICKS + refr);
  end
endmodule

// File: rtl/bst_seq.sv
module bst_seq
  import bst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  dur_t dur,
  output logic busy,
  output logic ready,
  output dur_t len
);
  dur_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ready <= 1'b0;
      cnt   <= '0;
      len   <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      ready <= 1'b0;
      cnt   <= dur - dur_t'(1);
      len   <= dur;
    end else if (busy) begin
      if (cnt == dur_t'(1)) begin
        ready <= 1'b1;
        busy  <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt - dur_t'(1);
      end
    end else begin
      ready <= 1'b0;
    end
  end

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != dur_t'(1)) |=> (busy && cnt == $past(cnt) - dur_t'(1)));
endmodule

// File: rtl/bus_speed_timer.sv
module bus_speed_timer
  import bst_pkg::*;
#(
  parameter int         LINE_TICKS    = 912,
  parameter int         BEAT_SHORT    = 14,
  parameter int         BEAT_LONG     = 16,
  parameter int         LONG_START    = 896,
  parameter int         WIN_TICKS     = 50,
  parameter int         FAST_TICKS    = 5,
  parameter int         REFRESH_START = 45,
  parameter int         REFRESH_TICKS = 5,
  parameter int         SLOTS         = 4,
  parameter logic [7:0] SPD_RESET     = 8'h40,
  localparam int        SPW = $clog2(LINE_TICKS),
  localparam int        FPW = $clog2(WIN_TICKS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic [15:0] acc_addr,
  input  logic        acc_write,
  input  logic        rgn_slow,
  input  logic        rgn_shadow,
  input  logic        rgn_ram,
  input  logic        spd_wr_en,
  input  logic [7:0]  spd_wr_data,
  output logic        acc_ready,
  output logic [5:0]  acc_len,
  output logic [7:0]  spd_q
);
  logic           busy, accept, slow;
  logic [SPW-1:0] sphase;
  logic [FPW-1:0] fphase;
  dur_t           slow_dur, fast_dur, dur, len;
  int             s_sum, f_sum;

  assign accept  = acc_valid && !busy;
  assign acc_len = len;

  always_ff @(posedge clk) begin
    if (rst)            spd_q <= SPD_RESET;
    else if (spd_wr_en) spd_q <= spd_wr_data;
  end

  bst_speed_sel #(.SLOTS(SLOTS)) u_sel (
    .clk(clk), .rst(rst), .accept(accept), .addr(acc_addr), .write(acc_write),
    .rgn_slow(rgn_slow), .rgn_shadow(rgn_shadow), .spd(spd_q), .slow(slow)
  );

  bst_slow_calc #(.LINE_TICKS(LINE_TICKS), .BEAT_SHORT(BEAT_SHORT),
                  .BEAT_LONG(BEAT_LONG), .LONG_START(LONG_START)) u_slow (
    .phase(sphase), .dur(slow_dur)
  );

  bst_fast_calc #(.WIN_TICKS(WIN_TICKS), .FAST_TICKS(FAST_TICKS),
                  .REFRESH_START(REFRESH_START), .REFRESH_TICKS(REFRESH_TICKS)) u_fast (
    .phase(fphase), .ram(rgn_ram), .dur(fast_dur)
  );

  assign dur = slow ? slow_dur : fast_dur;

  always_comb begin
    s_sum = int'(sphase) + int'(dur);
    if (s_sum >= LINE_TICKS) s_sum = s_sum - LINE_TICKS;
    f_sum = int'(fphase) + int'(dur);
    if (f_sum >= WIN_TICKS) f_sum = f_sum - WIN_TICKS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sphase <= '0;
      fphase <= '0;
    end else if (accept) begin
      sphase <= SPW'(s_sum);
      fphase <= FPW'(f_sum);
    end
  end

  bst_seq u_seq (
    .clk(clk), .rst(rst), .accept(accept), .dur(dur),
    .busy(busy), .ready(acc_ready), .len(len)
  );

  // R2
  spd_write_chk: assert property (@(posedge clk) disable iff (rst)
    spd_wr_en |=> spd_q == $past(spd_wr_data));
  // R9
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(sphase) < LINE_TICKS) && (int'(fphase) < WIN_TICKS));
  // R7
  fast_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !slow) |-> (int'(dur) >= FAST_TICKS &&
                           int'(dur) <= 2*FAST_TICKS - 1 + REFRESH_TICKS));
  // R6
  slow_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && slow) |-> (int'(dur) >= BEAT_SHORT && int'(dur) <= 2*BEAT_LONG - 1));
endmodule

// File: tb/bus_speed_timer_tb.sv
module bus_speed_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        rgn_slow = 1'b0, rgn_shadow = 1'b0, rgn_ram = 1'b0;
  logic        spd_wr_en = 1'b0;
  logic [7:0]  spd_wr_data = '0;
  logic        acc_ready;
  logic [5:0]  acc_len;
  logic [7:0]  spd_q;

  int total = 0, bad = 0;
  int m_fp = 0, m_sp = 0;
  logic [3:0] m_motor = '0;
  logic [7:0] m_spd = 8'h40;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_speed_timer u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .rgn_slow(rgn_slow), .rgn_shadow(rgn_shadow),
    .rgn_ram(rgn_ram), .spd_wr_en(spd_wr_en), .spd_wr_data(spd_wr_data),
    .acc_ready(acc_ready), .acc_len(acc_len), .spd_q(spd_q)
  );

  function automatic int slow_len(int p);
    int r, cl, w, s;
    r  = p % 14;
    cl = (p >= 896) ? 16 : 14;
    w  = (r == 0) ? 0 : cl - r;
    s  = (p + w) % 912;
    return w + ((s >= 896) ? 16 : 14);
  endfunction

  function automatic int fast_len(int f, bit ram);
    return ((5 - f % 5) % 5) + 5 + ((f >= 45 && ram) ? 5 : 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_spd(logic [7:0] v);
    spd_wr_en = 1'b1; spd_wr_data = v;
    @(posedge clk); @(negedge clk);
    spd_wr_en = 1'b0;
    check(spd_q == v, "R2 speed readback", int'(spd_q), int'(v));
    m_spd = v;
  endtask

  // Runs one access; junk=1 keeps a motor-set strobe high while busy (R11).
  task automatic access(logic [15:0] a, bit wr, bit sl, bit sh, bit ram, bit junk,
                        output int d);
    bit exp_slow;
    int lows;
    exp_slow = sl | ~m_spd[7] | (|(m_spd[3:0] & m_motor)) | (sh & wr);
    d = exp_slow ? slow_len(m_sp) : fast_len(m_fp, ram);
    m_fp = (m_fp + d) % 50;
    m_sp = (m_sp + d) % 912;
    if (a[15:8] == 8'hC0 && a[7:4] >= 4'hC && a[3:1] == 3'b100)
      m_motor[a[7:4] - 4'hC] = a[0];
    acc_addr = a; acc_write = wr; rgn_slow = sl; rgn_shadow = sh; rgn_ram = ram;
    acc_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    lows = 0;
    while (!acc_ready && lows < 100) begin
      lows++;
      if (junk) begin
        acc_valid = 1'b1;
        acc_addr  = {8'hC0, 4'hC + 4'($urandom_range(0, 3)), 4'h9};
        acc_write = $urandom_range(0, 1) != 0;
      end else acc_valid = 1'b0;
      @(negedge clk);
    end
    acc_valid = 1'b0;
    check(lows == d - 1, exp_slow ? "R10 R6 ready delay (slow)" : "R10 R7 R8 ready delay (fast)",
          lows, d - 1);
    check(int'(acc_len) == d, "R9 length output", int'(acc_len), d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, seed;
    seed = $urandom(32'h1D5E);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1
    check(spd_q == 8'h40, "R1 speed reset", int'(spd_q), 8'h40);
    check(acc_ready == 1'b0, "R1 ready reset", int'(acc_ready), 0);
    check(acc_len == 6'd0, "R1 length reset", int'(acc_len), 0);
    // R1 R3: bit 7 clear -> slow, phase 0 -> 14 ticks
    access(16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, d);
    check(d == 14, "R1 R3 first slow length", d, 14);
    set_spd(8'h80);
    // fast: phase 14 -> align 1 -> 6
    access(16'h0100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, d);
    check(d == 6, "R7 aligned fast length", d, 6);
    // R3 region slow
    access(16'h0200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, d);
    // R5 shadow write slow, shadow read fast
    access(16'h0400, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, d);
    access(16'h0400, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, d);
    // R4 motor detectors
    set_spd(8'h81);
    access(16'hC0C9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, d);
    access(16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, d);
    access(16'hC0C8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, d);
    access(16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, d);
    // R4 detector on but not enabled stays fast
    access(16'hC0F9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, d);
    access(16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, d);
    // R11 strobes during busy ignored
    access(16'h0020, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, d);
    access(16'h0030, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, d);
    // random mix
    for (int i = 0; i < 700; i++) begin
      logic [15:0] a;
      if ($urandom_range(0, 19) == 0)
        set_spd({$urandom_range(0, 5) != 0, 1'b1, 2'b00, 4'($urandom_range(0, 15))});
      if ($urandom_range(0, 3) == 0)
        a = {8'hC0, 4'hC + 4'($urandom_range(0, 3)), 3'b100, 1'($urandom_range(0, 1))};
      else
        a = 16'($urandom);
      access(a, $urandom_range(0, 1) != 0, $urandom_range(0, 7) == 0,
             $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0,
             $urandom_range(0, 5) == 0, d);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule